// File: doc/BRIEF.md
# Clock Mode Controller with Gating

This block decides which clock outputs of a multi-output clock generator run, at what rate, and whether the outputs are driven. It takes two active-low stop inputs, an active-low doze input and a two-bit processor rate select. All of them are asynchronous to the block. It then runs a small mode state machine that drives three clock groups built from one master clock: a processor clock, an early processor clock and a bus clock. It also drives an enable for the synthesis loop, a pad drive enable and a registered rate code for the processor synthesiser.

Every clock output comes from a register, and a group may only start or stop at the end of a whole phase, so no shortened pulse can appear. The block also enforces the power-down ordering. The only way into power-down is from the stop mode, after every gated clock has settled low. The only way out of power-down is back to the stop mode. A request that breaks this ordering is refused. The mode is held and a sticky sequence-error flag is raised.

Control code, written `{stop1_ni, stop0_ni, doze_ni}`, and the mode states (with the `mode_o` value of each):
- PDOWN (0) = code 000
- STOP (1) = code 001
- CPUSTOP (2) = codes 011 and 101
- DOZE (3) = code 110
- RUN (4) = code 111
- TRI (5) = codes 010 and 100

State transitions:
- Any state moves to the decoded target when the target differs from the current state, with these exceptions.
- STOP to PDOWN happens only when both clock groups are low; otherwise the block waits in STOP.
- A move to PDOWN from any other state is refused.
- PDOWN to STOP is the only way out of PDOWN; any other target is refused.

Top module: `clk_mode_ctrl`

## Requirements
- R1: A change on the control inputs shows on `mode_o` at the third rising clock edge after it is presented, because of two synchroniser flops and the state register.
- R2: The control code is decoded into the mode states exactly as listed above, and `mode_o` reports the state with the listed value.
- R3: In RUN the processor clock period is 2*CPU_HALF master cycles (4 by default) and the bus clock period is 2*BUS_HALF master cycles (8 by default). In DOZE both periods double and `cpu_half_o` is 1; in every other state `cpu_half_o` is 0.
- R4: Every high phase and every low phase of a running group lasts its whole half period (1x or 2x the group's HALF). A stop that arrives during a high phase lets that phase finish. A group always halts low.
- R5: `cpu_early_o` is equal to `cpu_clk_o` in every cycle.
- R6: In CPUSTOP the processor and early clocks are halted low and the bus clock keeps running. In STOP and TRI both groups are halted low.
- R7: PDOWN is entered only from STOP, and only once both groups are low. While in PDOWN, `pll_on_o` is 0 and all clock outputs are low; `pll_on_o` is 1 in every other state.
- R8: PDOWN is left only to STOP. Any refused transition into or out of PDOWN holds the current state and sets `seq_err_o`, which stays 1 until reset.
- R9: `drive_en_o` is 0 in TRI and 1 in all other states.
- R10: `cpu_fsel_o` follows `fsel_i` with the same three-edge latency as R1 (codes 00, 01, 10 and 11 select the fastest to the slowest processor rate). It holds its value while the state is PDOWN.
- R11: During reset the state is STOP, all clocks are low, `seq_err_o` is 0, `pll_on_o` and `drive_en_o` are 1, and `cpu_fsel_o` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; the source of every gated output |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop0_ni | input | 1 | Stop request bit 0, active low, asynchronous |
| stop1_ni | input | 1 | Stop request bit 1, active low, asynchronous |
| doze_ni | input | 1 | Doze request, active low, asynchronous |
| fsel_i | input | 2 | Processor rate select, asynchronous |
| cpu_clk_o | output | 1 | Gated processor clock |
| cpu_early_o | output | 1 | Early processor clock, gated with the processor group |
| bus_clk_o | output | 1 | Gated bus clock |
| cpu_fsel_o | output | 2 | Registered rate code for the processor synthesiser |
| cpu_half_o | output | 1 | 1 when the processor and bus rates are halved (DOZE) |
| pll_on_o | output | 1 | Synthesis loop enable, 0 in PDOWN |
| drive_en_o | output | 1 | Output pad drive enable, 0 in TRI |
| mode_o | output | 3 | Current mode state, encoded as listed above |
| seq_err_o | output | 1 | Sticky flag for a refused power-down transition |

## Verification
Two things can land in the same cycle. The first is a mode change that stops a group or halves its rate, arriving while that group's clock is high or at the very cycle a phase boundary falls due. The second is a power-down request arriving in STOP while the bus clock is still finishing its last high phase. The bench changes modes at arbitrary clock phases. A pulse-width monitor then judges every high phase and every low gap of both groups against the whole half-period lengths. An assertion confirms that the clocks are already low in each PDOWN cycle, and so that entry waited for the phase to close.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

    typedef enum logic [2:0] {
        M_PDOWN   = 3'd0,
        M_STOP    = 3'd1,
        M_CPUSTOP = 3'd2,
        M_DOZE    = 3'd3,
        M_RUN     = 3'd4,
        M_TRI     = 3'd5
    } mode_e;

    // code bits: {stop1_n, stop0_n, doze_n}
    function automatic mode_e decode_code(input logic [2:0] code);
        mode_e m;
        case (code)
            3'b000:         m = M_PDOWN;
            3'b001:         m = M_STOP;
            3'b111:         m = M_RUN;
            3'b110:         m = M_DOZE;
            3'b011, 3'b101: m = M_CPUSTOP;
            default:        m = M_TRI;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cm_sync.sv
module cm_sync #(
    parameter int          W       = 5,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cm_clk_gen.sv
module cm_clk_gen #(
    parameter int HALF = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic slow_i,
    output logic clk_o,
    output logic early_o
);
    localparam int           LW        = $clog2(2*HALF + 1);
    localparam logic [LW-1:0] LAST_FAST = LW'(HALF - 1);
    localparam logic [LW-1:0] LAST_SLOW = LW'(2*HALF - 1);

    logic [LW-1:0] cnt_q;
    logic          lvl_q, early_q, slow_q;
    logic [LW-1:0] last;
    logic          idle, flip;

    assign last = slow_q ? LAST_SLOW : LAST_FAST;
    assign idle = !lvl_q && !run_i;           // parked low, nothing to do
    assign flip = !idle && (cnt_q == last);   // phase boundary

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
            early_q <= 1'b0;
            slow_q  <= 1'b0;
        end else begin
            if (idle || flip) begin
                cnt_q  <= '0;
                slow_q <= slow_i;              // rate fixed for a whole phase
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            lvl_q   <= lvl_q ^ flip;
            early_q <= lvl_q ^ flip;
        end
    end

    assign clk_o   = lvl_q;
    assign early_o = early_q;

    // a high phase may only start while the group is enabled
    assert_rise_needs_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lvl_q) |-> $past(run_i));
endmodule

// File: rtl/cm_fsm.sv
module cm_fsm
    import clk_mode_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] code_i,
    input  logic       clocks_low_i,
    output mode_e      mode_o,
    output logic       err_o,
    output logic       cpu_run_o,
    output logic       bus_run_o,
    output logic       slow_o,
    output logic       pll_on_o,
    output logic       drive_en_o
);
    mode_e state_q, state_d, want;
    logic  err_q, refuse;

    assign want = decode_code(code_i);

    always_comb begin
        state_d = state_q;
        refuse  = 1'b0;
        if (want != state_q) begin
            if (want == M_PDOWN) begin
                if (state_q == M_STOP) begin
                    if (clocks_low_i) state_d = M_PDOWN;
                end else begin
                    refuse = 1'b1;
                end
            end else if (state_q == M_PDOWN) begin
                if (want == M_STOP) state_d = M_STOP;
                else                refuse  = 1'b1;
            end else begin
                state_d = want;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= M_STOP;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (refuse) err_q <= 1'b1;
        end
    end

    always_comb begin
        cpu_run_o  = 1'b0;
        bus_run_o  = 1'b0;
        slow_o     = 1'b0;
        pll_on_o   = 1'b1;
        drive_en_o = 1'b1;
        unique case (state_q)
            M_RUN:     begin cpu_run_o = 1'b1; bus_run_o = 1'b1; end
            M_DOZE:    begin cpu_run_o = 1'b1; bus_run_o = 1'b1; slow_o = 1'b1; end
            M_CPUSTOP: bus_run_o  = 1'b1;
            M_STOP:    ;
            M_PDOWN:   pll_on_o   = 1'b0;
            M_TRI:     drive_en_o = 1'b0;
            default:   ;
        endcase
    end

    assign mode_o = state_q;
    assign err_o  = err_q;

    assert_pd_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == M_PDOWN && $past(state_q) != M_PDOWN) |-> ($past(state_q) == M_STOP));
    assert_pd_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(state_q) == M_PDOWN && state_q != M_PDOWN) |-> (state_q == M_STOP));
    assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(err_q) |-> err_q);
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import clk_mode_pkg::*;
#(
    parameter int CPU_HALF = 2,
    parameter int BUS_HALF = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       stop0_ni,
    input  logic       stop1_ni,
    input  logic       doze_ni,
    input  logic [1:0] fsel_i,
    output logic       cpu_clk_o,
    output logic       cpu_early_o,
    output logic       bus_clk_o,
    output logic [1:0] cpu_fsel_o,
    output logic       cpu_half_o,
    output logic       pll_on_o,
    output logic       drive_en_o,
    output logic [2:0] mode_o,
    output logic       seq_err_o
);
    localparam int IN_W = 5;
    // synchronised reset value decodes to STOP with rate code 00
    localparam logic [IN_W-1:0] IN_RST = 5'b001_00;

    logic [IN_W-1:0] raw, syn;
    logic [1:0]      fsel_q;
    mode_e           mode;
    logic            cpu_run, bus_run, slow, bus_early_unused;

    assign raw = {stop1_ni, stop0_ni, doze_ni, fsel_i};

    cm_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
    );

    cm_fsm u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .code_i(syn[4:2]),
        .clocks_low_i(!cpu_clk_o && !bus_clk_o),
        .mode_o(mode), .err_o(seq_err_o),
        .cpu_run_o(cpu_run), .bus_run_o(bus_run), .slow_o(slow),
        .pll_on_o(pll_on_o), .drive_en_o(drive_en_o)
    );

    cm_clk_gen #(.HALF(CPU_HALF)) u_cpu_gen (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(cpu_run), .slow_i(slow),
        .clk_o(cpu_clk_o), .early_o(cpu_early_o)
    );

    cm_clk_gen #(.HALF(BUS_HALF)) u_bus_gen (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(bus_run), .slow_i(slow),
        .clk_o(bus_clk_o), .early_o(bus_early_unused)
    );

    // rate code register, frozen while the synthesis loop is off
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              fsel_q <= 2'b00;
        else if (mode != M_PDOWN) fsel_q <= syn[1:0];
    end

    assign cpu_fsel_o = fsel_q;
    assign cpu_half_o = slow;
    assign mode_o     = mode;

    assert_pd_clk_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == M_PDOWN) |-> (!cpu_clk_o && !bus_clk_o && !cpu_early_o));
    assert_pd_fsel_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(mode) == M_PDOWN) |-> $stable(cpu_fsel_o));
endmodule

// File: tb/clk_mode_ctrl_tb_top.sv
module clk_mode_ctrl_tb_top;
    localparam int CPU_H = 2;
    localparam int BUS_H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop0_n = 1'b0, stop1_n = 1'b0, doze_n = 1'b1;
    logic [1:0] fsel = 2'b00;
    logic cpu_clk, cpu_early, bus_clk, cpu_half, pll_on, drive_en, seq_err;
    logic [1:0] cpu_fsel;
    logic [2:0] mode;

    always #4 clk = ~clk;   // 125 MHz

    clk_mode_ctrl #(.CPU_HALF(CPU_H), .BUS_HALF(BUS_H)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .stop0_ni(stop0_n), .stop1_ni(stop1_n),
        .doze_ni(doze_n), .fsel_i(fsel), .cpu_clk_o(cpu_clk), .cpu_early_o(cpu_early),
        .bus_clk_o(bus_clk), .cpu_fsel_o(cpu_fsel), .cpu_half_o(cpu_half),
        .pll_on_o(pll_on), .drive_en_o(drive_en), .mode_o(mode), .seq_err_o(seq_err)
    );

    typedef struct packed {
        logic [2:0] mode;
        logic [7:0] cpu_per;   // 0 = halted low
        logic [7:0] bus_per;
        logic       oe;
        logic       pll;
        logic       half;
        logic [1:0] fsel;
        logic       err;
    } exp_t;

    exp_t sb_q[$];
    int   total = 0, fails = 0;
    bit   busy = 0, finished = 0;
    int   runt_cpu = 0, runt_bus = 0, early_bad = 0, pulses = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic sig(input int w);
        return (w == 0) ? cpu_clk : bus_clk;
    endfunction

    task automatic meas(input int w, output int per);
        logic prev, cur;
        bit   found;
        per = 0; found = 0; prev = sig(w);
        for (int i = 0; i < 60 && !found; i++) begin
            @(negedge clk); cur = sig(w);
            if (!prev && cur) found = 1;
            prev = cur;
        end
        if (found) begin
            found = 0;
            for (int i = 1; i <= 60 && !found; i++) begin
                @(negedge clk); cur = sig(w);
                if (!prev && cur) begin per = i; found = 1; end
                prev = cur;
            end
        end
    endtask

    // driver: apply a code, let it settle, push the expectation
    task automatic drive(input logic [2:0] code, input logic [1:0] fs, input exp_t e);
        @(negedge clk);
        {stop1_n, stop0_n, doze_n} = code;
        fsel = fs;
        repeat (40) @(negedge clk);
        sb_q.push_back(e);
        @(negedge clk);
        wait (sb_q.size() == 0 && !busy);
    endtask

    // monitor: pop and compare against what the design produces
    initial begin
        forever begin
            exp_t e;
            int   p;
            wait (sb_q.size() > 0);
            busy = 1;
            e = sb_q.pop_front();
            chk("R2", "mode", mode, e.mode);
            chk("R9", "drive_en", drive_en, e.oe);
            chk("R7", "pll_on", pll_on, e.pll);
            chk("R3", "cpu_half", cpu_half, e.half);
            chk("R10", "cpu_fsel", cpu_fsel, e.fsel);
            chk("R8", "seq_err", seq_err, e.err);
            meas(0, p); chk("R3/R6 cpu", "period", p, e.cpu_per);
            if (e.cpu_per == 0) chk("R6", "cpu level", cpu_clk, 0);
            meas(1, p); chk("R3/R6 bus", "period", p, e.bus_per);
            if (e.bus_per == 0) chk("R6", "bus level", bus_clk, 0);
            busy = 0;
        end
    end

    // continuous pulse-width and early-clock monitor (R4, R5)
    int hi_c = 0, lo_c = 0, hi_b = 0, lo_b = 0;
    bit seen_c = 0, seen_b = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cpu_early !== cpu_clk) early_bad++;
            if (cpu_clk) begin
                if (hi_c == 0 && seen_c && lo_c < CPU_H) runt_cpu++;
                hi_c++; lo_c = 0;
            end else begin
                if (hi_c > 0) begin
                    if (hi_c != CPU_H && hi_c != 2*CPU_H) runt_cpu++;
                    seen_c = 1; pulses++;
                end
                hi_c = 0; lo_c++;
            end
            if (bus_clk) begin
                if (hi_b == 0 && seen_b && lo_b < BUS_H) runt_bus++;
                hi_b++; lo_b = 0;
            end else begin
                if (hi_b > 0) begin
                    if (hi_b != BUS_H && hi_b != 2*BUS_H) runt_bus++;
                    seen_b = 1;
                end
                hi_b = 0; lo_b++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk("R11", "mode", mode, 1);
        chk("R11", "cpu_clk", cpu_clk, 0);
        chk("R11", "bus_clk", bus_clk, 0);
        chk("R11", "seq_err", seq_err, 0);
        chk("R11", "pll_on", pll_on, 1);
        chk("R11", "drive_en", drive_en, 1);
        chk("R11", "cpu_fsel", cpu_fsel, 0);
        rst_n = 1'b1;

        //          code    fsel   mode cpu bus oe pll half fsel err
        drive(3'b111, 2'b00, '{3'd4, 8'd4, 8'd8, 1, 1, 0, 2'd0, 0});

        // R1 / R10 latency: RUN -> DOZE with new rate code
        @(negedge clk);
        {stop1_n, stop0_n, doze_n} = 3'b110; fsel = 2'b10;
        @(negedge clk); chk("R1", "mode after 1 edge", mode, 4);
        @(negedge clk); chk("R1", "mode after 2 edges", mode, 4);
        chk("R10", "fsel after 2 edges", cpu_fsel, 0);
        @(negedge clk); chk("R1", "mode after 3 edges", mode, 3);
        chk("R10", "fsel after 3 edges", cpu_fsel, 2);
        drive(3'b110, 2'b10, '{3'd3, 8'd8, 8'd16, 1, 1, 1, 2'd2, 0});

        drive(3'b101, 2'b10, '{3'd2, 8'd0, 8'd8, 1, 1, 0, 2'd2, 0});   // R6 CPUSTOP
        drive(3'b000, 2'b10, '{3'd2, 8'd0, 8'd8, 1, 1, 0, 2'd2, 1});   // R8 refused entry
        drive(3'b001, 2'b10, '{3'd1, 8'd0, 8'd0, 1, 1, 0, 2'd2, 1});   // STOP
        drive(3'b000, 2'b10, '{3'd0, 8'd0, 8'd0, 1, 0, 0, 2'd2, 1});   // R7 PDOWN
        drive(3'b111, 2'b01, '{3'd0, 8'd0, 8'd0, 1, 0, 0, 2'd2, 1});   // R8 refused exit, R10 hold
        drive(3'b001, 2'b01, '{3'd1, 8'd0, 8'd0, 1, 1, 0, 2'd1, 1});   // R8 exit via STOP
        drive(3'b111, 2'b11, '{3'd4, 8'd4, 8'd8, 1, 1, 0, 2'd3, 1});
        drive(3'b100, 2'b11, '{3'd5, 8'd0, 8'd0, 0, 1, 0, 2'd3, 1});   // R9 TRI
        drive(3'b000, 2'b11, '{3'd5, 8'd0, 8'd0, 0, 1, 0, 2'd3, 1});   // R8 refused from TRI
        drive(3'b011, 2'b11, '{3'd2, 8'd0, 8'd8, 1, 1, 0, 2'd3, 1});   // R2 other CPUSTOP code
        drive(3'b010, 2'b11, '{3'd5, 8'd0, 8'd0, 0, 1, 0, 2'd3, 1});   // R2 other TRI code
        drive(3'b110, 2'b00, '{3'd3, 8'd8, 8'd16, 1, 1, 1, 2'd0, 1});

        chk("R4", "cpu runt pulses", runt_cpu, 0);
        chk("R4", "bus runt pulses", runt_bus, 0);
        chk("R4", "cpu pulses seen", (pulses > 0) ? 1 : 0, 1);
        chk("R5", "early/cpu mismatches", early_bad, 0);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule